// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a bus target that gives an I2C host access to a small bank of 8-bit configuration registers. It samples the SCL and SDA lines on a single fast system clock, finds start, repeated-start and stop conditions, and drives SDA only through an open-drain enable. When the enable is high, the line is pulled low. When the enable is low, the line is left to the pull-up.

A host writes a register by sending the target address with the direction bit clear, then a register index, then exactly one data byte. To read, the host sends the target address and the register index in the same way. It then issues a repeated start and the target address with the direction bit set, and the target returns that register MSB first. The register storage itself sits outside the block. The block offers a parallel port for it: a register index that is held after it is accepted, a one-cycle write strobe with its data, and a read-data input that the block samples when it starts a read.

Top module: `i2c_reg_target`

## Requirements
- R1: A start or repeated start in any state aborts the current transfer and returns the target to address matching. A stop returns it to idle with SDA released.
- R2: The target changes its SDA drive only while the synchronized SCL is low. A new drive value follows a falling SCL edge.
- R3: When the 7 address bits, sent MSB first, equal TGT_ADDR (default 7'h2A), the target pulls SDA low during the ninth SCL pulse. It releases SDA after the falling edge that ends that pulse.
- R4: On an address that does not match, the target never drives SDA until the next start.
- R5: The byte after the address (direction bit 0) is a register index. An index below NUM_REGS (default 8) is acknowledged and appears on reg_addr. Any other index gets no acknowledge, leaves reg_addr unchanged and blocks any write in that transfer.
- R6: The data byte that follows an accepted index is acknowledged. It produces exactly one single-cycle reg_wr_en pulse with reg_wr_data equal to the byte and reg_addr equal to the index.
- R7: Only one data byte is taken per write. A further byte in the same transfer gets no acknowledge and causes no write.
- R8: After a repeated start and a matching address with direction bit 1, the target acknowledges. Starting on the falling edge after that acknowledge, it shifts out the register selected by reg_addr, MSB first.
- R9: After the eighth read bit, the target releases SDA for the host acknowledge slot. Whether the host sends ACK or NACK, the target does not drive SDA again in that transfer.
- R10: A stop or start that arrives before all eight data bits have been received causes no write.
- R11: Following reset, sda_oe and reg_wr_en are 0 and reg_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level, as resolved on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Latched register index |
| reg_wr_data | output | 8 | Data for the write strobe |
| reg_rd_data | input | 8 | Contents of the register at reg_addr |

## Verification
A wrong state in the transfer sequencer shows up on SDA within one SCL bit time. There are three ways it can appear: an acknowledge where none is due, a missing acknowledge, or a read bit that arrives one slot early or late. A wrong bit count or a wrong pointer shows at the register port. The write strobe then carries the wrong data or index, or arrives on an aborted transfer, and a read-back of every register exposes it in the next transaction. A drive change while SCL is high would be taken as a false start or stop. It is caught on the cycle it happens.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared types for the I2C register-access target.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,     // bus free, waiting for a start
        ST_DEV,      // shifting in target address and direction bit
        ST_DEV_ACK,  // address acknowledge slot
        ST_REG,      // shifting in register index
        ST_REG_ACK,  // index acknowledge slot
        ST_WDATA,    // shifting in write data (or awaiting repeated start)
        ST_WACK,     // write data acknowledge slot
        ST_RDATA,    // shifting out read data
        ST_RACK,     // host acknowledge slot after read byte
        ST_HOLD      // ignore bus until the next start or stop
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clk domain through STAGES flip-flops and
// flags SCL edges plus start and stop conditions, one cycle each.
// Assumes: clk runs at least 8x SCL, STAGES >= 2, lines idle high.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains and one-cycle-delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and bus-condition decode on the synchronized levels.
    always_comb begin
        scl_lvl   = scl_pipe[STAGES-1];
        sda_lvl   = sda_pipe[STAGES-1];
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end

endmodule

// File: rtl/i2c_tgt_fsm.sv
// Module: i2c_tgt_fsm
// Transfer sequencer: address match, index latch, one-byte write,
// random read, acknowledge generation and open-drain SDA control.
// Assumes: inputs come from i2c_line_sync; data sampled on SCL rise,
// drive changes only on SCL fall.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h2A,
    parameter int         NUM_REGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    output logic       sda_oe,
    output logic       reg_wr_en,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wr_data,
    input  logic [7:0] reg_rd_data
);

    localparam logic [8:0] REG_LIMIT = 9'(NUM_REGS);

    tgt_state_t state;
    logic [7:0] shreg;
    logic [2:0] bitcnt;
    logic       ack_on;
    logic       rw_q;
    logic [7:0] byte_in;

    // Byte as completed by the bit now on SDA.
    always_comb byte_in = {shreg[6:0], sda_lvl};

    // Main sequencer: conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            shreg       <= '0;
            bitcnt      <= '0;
            ack_on      <= 1'b0;
            rw_q        <= 1'b0;
            sda_oe      <= 1'b0;
            reg_wr_en   <= 1'b0;
            reg_addr    <= '0;
            reg_wr_data <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                ack_on <= 1'b0;
            end else if (start_det) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
                ack_on <= 1'b0;
            end else begin
                case (state)
                    ST_DEV: if (scl_rise) begin
                        shreg  <= byte_in;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            rw_q  <= sda_lvl;
                            state <= (shreg[6:0] == TGT_ADDR) ? ST_DEV_ACK : ST_HOLD;
                        end
                    end
                    ST_REG: if (scl_rise) begin
                        shreg  <= byte_in;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            if ({1'b0, byte_in} < REG_LIMIT) begin
                                reg_addr <= byte_in;
                                state    <= ST_REG_ACK;
                            end else begin
                                state    <= ST_HOLD;
                            end
                        end
                    end
                    ST_WDATA: if (scl_rise) begin
                        shreg  <= byte_in;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            reg_wr_en   <= 1'b1;
                            reg_wr_data <= byte_in;
                            state       <= ST_WACK;
                        end
                    end
                    ST_DEV_ACK, ST_REG_ACK, ST_WACK: if (scl_fall) begin
                        if (!ack_on) begin
                            sda_oe <= 1'b1;
                            ack_on <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            bitcnt <= '0;
                            sda_oe <= 1'b0;
                            if (state == ST_DEV_ACK && rw_q) begin
                                shreg  <= reg_rd_data;
                                sda_oe <= ~reg_rd_data[7];
                                state  <= ST_RDATA;
                            end else if (state == ST_DEV_ACK) begin
                                state  <= ST_REG;
                            end else if (state == ST_REG_ACK) begin
                                state  <= ST_WDATA;
                            end else begin
                                state  <= ST_HOLD;
                            end
                        end
                    end
                    ST_RDATA: if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe <= ~shreg[6];
                            shreg  <= {shreg[6:0], 1'b0};
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                    ST_RACK: if (scl_rise) state <= ST_HOLD;
                    default: ;
                endcase
            end
        end
    end

    // Drive may only move while SCL is low.
    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);  // R2
    // A stop always frees the line and idles.
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && state == ST_IDLE));  // R1
    // A start always restarts address matching.
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_DEV));  // R1
    // Ignoring the bus means never pulling SDA.
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !sda_oe);  // R4
    // Write strobe lasts one cycle.
    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);  // R6
    // Writes only target implemented registers.
    AST_WR_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> ({1'b0, reg_addr} < REG_LIMIT));  // R5

endmodule

// File: rtl/i2c_reg_target.sv
// Module: i2c_reg_target (top)
// I2C target exposing NUM_REGS 8-bit registers through a parallel port.
// Assumes: clk >= 8x SCL, external pull-up, register file outside.
module i2c_reg_target #(
    parameter logic [6:0] TGT_ADDR    = 7'h2A,
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       reg_wr_en,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wr_data,
    input  logic [7:0] reg_rd_data
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.TGT_ADDR(TGT_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_lvl     (scl_lvl),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .sda_oe      (sda_oe),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data)
    );

endmodule

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;

    localparam logic [6:0] DEV = 7'h2A;
    localparam int         NR  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       sda_oe;
    logic       reg_wr_en;
    logic [7:0] reg_addr;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;
    logic       sda_bus;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    logic [7:0] last_wa, last_wd;
    logic [7:0] rf [NR];
    logic [7:0] expv [NR];
    int  drv_viol = 0;
    logic oe_prev = 1'b0;
    logic oe_seen = 1'b0;
    logic mon_on = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_h & ~sda_oe;
    assign reg_rd_data = rf[reg_addr[2:0]];

    i2c_reg_target u_i2c_reg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
        .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
    );

    // Register file model and port monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) rf[i] <= 8'h00;
        end else begin
            if (reg_wr_en) begin
                rf[reg_addr[2:0]] <= reg_wr_data;
                wr_cnt  <= wr_cnt + 1;
                last_wa <= reg_addr;
                last_wd <= reg_wr_data;
            end
            if (mon_on && sda_oe != oe_prev && scl_h) drv_viol <= drv_viol + 1;
            if (sda_oe) oe_seen <= 1'b1;
            oe_prev <= sda_oe;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_x(input logic b, output logic smp);
        scl_h = 1'b0; w(4);
        sda_h = b;    w(4);
        scl_h = 1'b1; w(4);
        smp = sda_bus; w(4);
    endtask

    task automatic do_start();
        scl_h = 1'b0; w(4);
        sda_h = 1'b1; w(4);
        scl_h = 1'b1; w(8);
        sda_h = 1'b0; w(8);
    endtask

    task automatic do_stop();
        scl_h = 1'b0; w(4);
        sda_h = 1'b0; w(4);
        scl_h = 1'b1; w(8);
        sda_h = 1'b1; w(8);
    endtask

    // Sends a byte MSB first; acked=1 when the target pulled the ninth slot low.
    task automatic tx_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_x(b[i], s);
        bit_x(1'b1, s);
        acked = ~s;
    endtask

    task automatic rx_byte(input logic host_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_x(1'b1, s);
            b[i] = s;
        end
        bit_x(~host_ack, s);
    endtask

    function automatic logic [7:0] pat(input int r, input int k);
        return 8'((r * 37 + k * 91 + 5) & 8'hFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic a1, a2, a3, a4;
        logic [7:0] rd;
        int wc;
        for (int i = 0; i < NR; i++) expv[i] = 8'h00;
        w(5);
        // R11: reset state
        chk(sda_oe == 1'b0, "R11 oe", sda_oe, 0);
        chk(reg_wr_en == 1'b0, "R11 wr_en", reg_wr_en, 0);
        chk(reg_addr == 8'h00, "R11 reg_addr", reg_addr, 0);
        rst_n = 1'b1;
        w(4);
        oe_prev = sda_oe;
        mon_on = 1'b1;

        // Write sweep, two passes, all registers: R3 R5 R6
        for (int k = 0; k < 2; k++) begin
            for (int r = 0; r < NR; r++) begin
                wc = wr_cnt;
                do_start();
                tx_byte({DEV, 1'b0}, a1);
                tx_byte(8'(r), a2);
                tx_byte(pat(r, k), a3);
                do_stop();
                expv[r] = pat(r, k);
                chk(a1, "R3 addr ack", a1, 1);
                chk(a2, "R5 index ack", a2, 1);
                chk(a3, "R6 data ack", a3, 1);
                chk(wr_cnt == wc + 1, "R6 write count", wr_cnt - wc, 1);
                chk(last_wa == 8'(r) && last_wd == pat(r, k), "R6 write content",
                    {last_wa, last_wd}, {8'(r), pat(r, k)});
            end
        end

        // Read sweep with alternating host ACK/NACK: R8 R9
        for (int r = NR - 1; r >= 0; r--) begin
            do_start();
            tx_byte({DEV, 1'b0}, a1);
            tx_byte(8'(r), a2);
            do_start();
            tx_byte({DEV, 1'b1}, a3);
            rx_byte(r[0], rd);
            chk(a3, "R8 read addr ack", a3, 1);
            chk(rd == expv[r], "R8 read data", rd, expv[r]);
            w(8);
            chk(sda_oe == 1'b0, "R9 released after read", sda_oe, 0);
            oe_seen = 1'b0;
            scl_h = 1'b0; w(16); scl_h = 1'b1; w(16);
            chk(oe_seen == 1'b0, "R9 no drive after host slot", oe_seen, 0);
            do_stop();
        end

        // Invalid register indices: R5
        for (int r = NR; r < NR + 9; r++) begin
            logic [7:0] idx;
            idx = (r == NR + 8) ? 8'hFF : 8'(r);
            wc = wr_cnt;
            do_start();
            tx_byte({DEV, 1'b0}, a1);
            tx_byte(idx, a2);
            tx_byte(8'h5A, a3);
            do_stop();
            chk(!a2, "R5 bad index nack", a2, 0);
            chk(!a3 && wr_cnt == wc, "R5 no write after bad index", wr_cnt - wc, 0);
            chk(reg_addr == 8'h00, "R5 pointer unchanged", reg_addr, 0);
        end

        // Non-matching target addresses: R4
        for (int k = 0; k < 7; k++) begin
            oe_seen = 1'b0;
            do_start();
            tx_byte({DEV ^ 7'(1 << k), 1'b0}, a1);
            tx_byte(8'h01, a2);
            do_stop();
            chk(!a1 && !a2 && !oe_seen, "R4 foreign address untouched", oe_seen, 0);
        end

        // Second data byte refused: R7
        wc = wr_cnt;
        do_start();
        tx_byte({DEV, 1'b0}, a1);
        tx_byte(8'h03, a2);
        tx_byte(8'hC3, a3);
        tx_byte(8'h3C, a4);
        do_stop();
        expv[3] = 8'hC3;
        chk(a3 && !a4, "R7 second byte nack", a4, 0);
        chk(wr_cnt == wc + 1 && rf[3] == 8'hC3, "R7 single write", rf[3], 8'hC3);

        // Stop mid data byte: R10
        wc = wr_cnt;
        do_start();
        tx_byte({DEV, 1'b0}, a1);
        tx_byte(8'h02, a2);
        for (int i = 0; i < 4; i++) bit_x(1'b0, a3);
        do_stop();
        chk(wr_cnt == wc && rf[2] == expv[2], "R10 stop abort no write", rf[2], expv[2]);

        // Repeated start mid data byte aborts and restarts matching: R1 R10
        wc = wr_cnt;
        do_start();
        tx_byte({DEV, 1'b0}, a1);
        tx_byte(8'h05, a2);
        for (int i = 0; i < 3; i++) bit_x(1'b1, a3);
        do_start();
        tx_byte({DEV, 1'b1}, a3);
        rx_byte(1'b0, rd);
        do_stop();
        chk(a3, "R1 restart address ack", a3, 1);
        chk(rd == expv[5] && wr_cnt == wc, "R1 abort then read", rd, expv[5]);

        // Stop released and idle: R1
        w(8);
        chk(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);

        // Drive changes only with SCL low: R2
        chk(drv_viol == 0, "R2 drive while SCL high", drv_viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule